// File: doc/BRIEF.md
# Partitioned SIMD Lane Adder

This block adds two 128-bit packed vectors lane by lane. A two-bit lane-size select, sampled with each operation, decides whether the vectors are treated as sixteen 8-bit lanes, eight 16-bit lanes or four 32-bit lanes. The lane count is always the vector width divided by the element width. Every lane receives the same add at the same time: lane k of the first operand is added to lane k of the second.

One ripple datapath made of byte-wide slices serves all three widths. At each slice boundary the incoming carry is either forwarded or cut, depending on the chosen lane width. A carry therefore never crosses from one lane into the next, and each lane wraps modulo its own width. The sum is captured in an output register, so there is one cycle of latency from the input strobe to the output strobe.

Top module: `simd_lane_adder`

## Requirements
- R1: While rst_ni is low, and after its release until the first accepted operation, valid_o is 0 and sum_o is all zeros.
- R2: valid_o is high in the cycle after a cycle with valid_i high, and is low in the cycle after a cycle with valid_i low.
- R3: With lane_mode_i = 2'b00, each 8-bit lane of sum_o equals (opa + opb) mod 2^8 for the matching lanes.
- R4: With lane_mode_i = 2'b01, each 16-bit lane of sum_o equals (opa + opb) mod 2^16 for the matching lanes.
- R5: With lane_mode_i = 2'b10, each 32-bit lane of sum_o equals (opa + opb) mod 2^32 for the matching lanes.
- R6: A carry out of the top bit of a lane never reaches the next lane. For example, all-ones plus one in every lane gives all zeros in every lane width.
- R7: lane_mode_i = 2'b11 is reserved. An accepted operation with this code yields sum_o = 0 and still raises valid_o.
- R8: Lane 0 occupies the least significant bits, and lane k of width w occupies bits [k*w+w-1 : k*w].
- R9: In a cycle with valid_i low, sum_o keeps its previous value whatever the operands and select are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe for the operands and select |
| lane_mode_i | input | 2 | Lane width: 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 = reserved |
| opa_i | input | 128 | First packed operand |
| opb_i | input | 128 | Second packed operand |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| sum_o | output | 128 | Registered packed sum |

## Verification
Two things happen in the same add: a carry ripples across a byte slice inside a lane, and a carry is cut at a lane edge. Operands of all ones plus one in every lane, and random operands biased toward 0xFF bytes, drive long carries into every slice boundary. Each such case is run under all three widths, back to back, with the select changing on every cycle. Every result is compared with a bit-serial reference model in the bench. That model clears its carry at each lane start, so a carry that leaks across a lane edge, or one that is wrongly cut inside a lane, appears as a mismatch in the lane concerned.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  parameter int unsigned VEC_W   = 128;
  parameter int unsigned SEG_W   = 8;
  parameter int unsigned NUM_SEG = VEC_W / SEG_W;

  typedef enum logic [1:0] {
    LANE_B8  = 2'b00,
    LANE_H16 = 2'b01,
    LANE_W32 = 2'b10,
    LANE_RSV = 2'b11
  } lane_mode_e;
endpackage

// File: rtl/lane_cut_gen.sv
// Marks every byte slice that starts a new lane; the carry into such a slice is cut.
module lane_cut_gen
  import simd_add_pkg::*;
#(
  parameter int unsigned N_SEG = NUM_SEG
) (
  input  lane_mode_e       mode_i,
  output logic [N_SEG-1:0] cut_o,
  output logic             mode_ok_o
);
  for (genvar k = 0; k < N_SEG; k++) begin : g_cut
    localparam bit START_H = (k % 2) == 0;
    localparam bit START_W = (k % 4) == 0;
    always_comb begin
      unique case (mode_i)
        LANE_B8:  cut_o[k] = 1'b1;
        LANE_H16: cut_o[k] = START_H;
        LANE_W32: cut_o[k] = START_W;
        default:  cut_o[k] = 1'b1;
      endcase
    end
  end

  assign mode_ok_o = (mode_i != LANE_RSV);
endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  assign {co_o, s_o} = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci_i};
endmodule

// File: rtl/packed_add_core.sv
module packed_add_core #(
  parameter int unsigned VW = 128,
  parameter int unsigned SW = 8
) (
  input  logic [VW-1:0]    opa_i,
  input  logic [VW-1:0]    opb_i,
  input  logic [VW/SW-1:0] cut_i,
  output logic [VW-1:0]    sum_o
);
  localparam int unsigned NS = VW / SW;

  logic [NS-1:0] co;
  logic [NS-1:0] ci;

  for (genvar k = 0; k < NS; k++) begin : g_seg
    if (k == 0) begin : g_first
      assign ci[k] = 1'b0;
    end else begin : g_rest
      assign ci[k] = co[k-1] & ~cut_i[k];
    end
    seg_adder #(.W(SW)) i_seg (
      .a_i (opa_i[k*SW +: SW]),
      .b_i (opb_i[k*SW +: SW]),
      .ci_i(ci[k]),
      .s_o (sum_o[k*SW +: SW]),
      .co_o(co[k])
    );
  end

  // The slice 0 boundary is always a lane start; the final carry out is discarded.
  logic unused_tail;
  assign unused_tail = co[NS-1] ^ cut_i[0];
endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import simd_add_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [1:0]         lane_mode_i,
  input  logic [VEC_W-1:0]   opa_i,
  input  logic [VEC_W-1:0]   opb_i,
  output logic               valid_o,
  output logic [VEC_W-1:0]   sum_o
);
  logic [NUM_SEG-1:0] cut;
  logic               mode_ok;
  logic [VEC_W-1:0]   raw_sum;
  logic [VEC_W-1:0]   sum_d;

  lane_cut_gen #(.N_SEG(NUM_SEG)) i_cut (
    .mode_i   (lane_mode_e'(lane_mode_i)),
    .cut_o    (cut),
    .mode_ok_o(mode_ok)
  );

  packed_add_core #(.VW(VEC_W), .SW(SEG_W)) i_core (
    .opa_i(opa_i),
    .opb_i(opb_i),
    .cut_i(cut),
    .sum_o(raw_sum)
  );

  assign sum_d = mode_ok ? raw_sum : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) sum_o <= sum_d;
    end
  end
endmodule

// File: rtl/simd_lane_adder_chk.sv
module simd_lane_adder_chk
  import simd_add_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       lane_mode_i,
  input logic [VEC_W-1:0] opa_i,
  input logic [VEC_W-1:0] opb_i,
  input logic             valid_o,
  input logic [VEC_W-1:0] sum_o
);
  // Set once a clock edge has been seen out of reset, so that $past never reaches into reset.
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) !rst_ni |-> (!valid_o && sum_o == '0));

  // R2
  valid_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (valid_o == $past(valid_i)));

  // R9
  sum_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sum_o));

  // R7
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lane_mode_i == 2'b11) |=> (sum_o == '0));

  // R3
  byte_lane0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && valid_o && $past(lane_mode_i) == 2'b00 |->
      sum_o[7:0] == 8'($past(opa_i[7:0]) + $past(opb_i[7:0])));

  // R5
  word_lane0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && valid_o && $past(lane_mode_i) == 2'b10 |->
      sum_o[31:0] == 32'($past(opa_i[31:0]) + $past(opb_i[31:0])));
endmodule

bind simd_lane_adder simd_lane_adder_chk i_chk (.*);

// File: tb/test_simd_lane_adder.sv
`timescale 1ns/1ps
module test_simd_lane_adder;
  localparam int W = 128;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   lane_mode_i = 2'b00;
  logic [W-1:0] opa_i = '0;
  logic [W-1:0] opb_i = '0;
  logic         valid_o;
  logic [W-1:0] sum_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  simd_lane_adder i_simd_lane_adder (.*);

  // Bit-serial reference: the carry is cleared at every lane start.
  function automatic logic [W-1:0] ref_sum(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] m);
    logic [W-1:0] s = '0;
    logic c = 1'b0;
    int lw;
    if (m == 2'b11) return '0;
    lw = 8 << m;
    for (int i = 0; i < W; i++) begin
      if (i % lw == 0) c = 1'b0;
      s[i] = a[i] ^ b[i] ^ c;
      c = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    return s;
  endfunction

  function automatic string mode_req(logic [1:0] m);
    case (m)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [W-1:0] rnd_vec(bit bias);
    logic [W-1:0] v;
    for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
    if (bias)
      for (int i = 0; i < W / 8; i++) if ($urandom_range(0, 2) == 0) v[i*8 +: 8] = 8'hFF;
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one operation; check its result one negedge later; leave valid_i low.
  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] m, string req);
    logic [W-1:0] e;
    e = ref_sum(a, b, m);
    @(negedge clk_i);
    opa_i = a; opb_i = b; lane_mode_i = m; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    opa_i = rnd_vec(0); opb_i = rnd_vec(0); lane_mode_i = 2'($urandom);
    check(sum_o == e, req, sum_o, e);
    check(valid_o == 1'b1, "R2", W'(valid_o), W'(1));
  endtask

  // valid_i low for a cycle: strobe drops, sum holds (R9, R2)
  task automatic idle_check(logic [W-1:0] prev);
    @(negedge clk_i);
    check(valid_o == 1'b0, "R2", W'(valid_o), W'(0));
    check(sum_o == prev, "R9", sum_o, prev);
  endtask

  task automatic run();
    logic [W-1:0] ones = '1;
    logic [W-1:0] a, b, e_prev;
    logic [1:0]   m_prev;
    // R1
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0 && sum_o == '0, "R1", sum_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(valid_o == 1'b0 && sum_o == '0, "R1", sum_o, '0);

    // R6: all ones plus one in every lane gives zero
    begin
      logic [W-1:0] one8, one16, one32;
      for (int i = 0; i < W / 8;  i++) one8[i*8 +: 8]    = 8'd1;
      for (int i = 0; i < W / 16; i++) one16[i*16 +: 16] = 16'd1;
      for (int i = 0; i < W / 32; i++) one32[i*32 +: 32] = 32'd1;
      apply(ones, one8,  2'b00, "R6");
      apply(ones, one16, 2'b01, "R6");
      apply(ones, one32, 2'b10, "R6");
      // carry inside a lane must still ripple across a byte edge
      apply({W{1'b0}} | 128'hFF, 128'h01, 2'b01, "R4");
      apply({W{1'b0}} | 128'hFFFFFF, 128'h01, 2'b10, "R5");
      apply({W{1'b0}} | 128'hFF, 128'h01, 2'b00, "R6");
    end

    // R8: only lane 0 nonzero lands in the low bits; top lane stays in the top bits
    apply(128'h7F, 128'h05, 2'b00, "R8");
    apply({32'h1234_5678, 96'h0}, {32'h0000_0001, 96'h0}, 2'b10, "R8");

    // R7: reserved code clears the sum and still raises the strobe
    apply(ones, ones, 2'b11, "R7");
    apply(rnd_vec(0), rnd_vec(0), 2'b11, "R7");

    // R9: hold while idle
    a = rnd_vec(0); b = rnd_vec(0);
    apply(a, b, 2'b01, "R4");
    idle_check(ref_sum(a, b, 2'b01));
    idle_check(ref_sum(a, b, 2'b01));

    // Random single operations with idle gaps
    for (int n = 0; n < 300; n++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      a = rnd_vec(n[0]); b = rnd_vec(n[1]);
      apply(a, b, m, mode_req(m));
      if (n % 5 == 0) idle_check(ref_sum(a, b, m));
    end

    // Back-to-back bursts with the select changing every cycle (R2, R3, R4, R5)
    @(negedge clk_i);
    e_prev = '0; m_prev = 2'b00;
    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      m = 2'(n % 3);
      a = rnd_vec(1); b = rnd_vec(1);
      opa_i = a; opb_i = b; lane_mode_i = m; valid_i = 1'b1;
      if (n > 0) begin
        check(sum_o == e_prev, mode_req(m_prev), sum_o, e_prev);
        check(valid_o == 1'b1, "R2", W'(valid_o), W'(1));
      end
      e_prev = ref_sum(a, b, m); m_prev = m;
      @(negedge clk_i);
    end
    valid_i = 1'b0;
    check(sum_o == e_prev, mode_req(m_prev), sum_o, e_prev);
    idle_check(e_prev);
  endtask

  initial begin
    bit timed_out = 0;
    void'($urandom(32'h5EED_0128));
    fork
      run();
      begin
        repeat (200000) @(posedge clk_i);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule